// File: doc/BRIEF.md
# Round-Robin Backplane Bus Bridge

This block connects two internal masters, a processor port and an I/O-controller port, to one exported backplane bus. The backplane has a 16-bit data path and separate address and data lines. It runs one non-pipelined transfer at a time. Each beat takes an address cycle, then at least one cycle in which the acknowledge is sampled. The bridge keeps the beat steady through any wait states the slave adds.

A master asks for service by raising its request and holding it, together with its command, until the bridge returns its completion pulse. A byte or halfword access is one beat. A 64-bit access becomes four beats at ascending addresses. Read beats are gathered into the master's 64-bit read-data register. When both masters request, priority alternates between them after each completed request. The 64-bit internal address is reduced to the 41 lines the backplane carries: the top ten bits and bits 31:1.

Top module: `bp_bridge`

## Requirements
- R1: After reset, bus_cyc, bus_stb, cpu_done and io_done are all low.
- R2: A beat drives bus_cyc and bus_stb high for one address cycle and then at least one acknowledge cycle. A beat with no wait states therefore keeps bus_stb high for exactly 2 clocks. A new request is accepted only after the previous one has completed.
- R3: bus_adr[40:31] carries internal address bits 63:54 and bus_adr[30:0] carries bits 31:1 of the beat's byte address. Internal bits 53:32 have no effect on the bus.
- R4: While bus_ack stays low in an acknowledge cycle, bus_adr, bus_sel, bus_we, bus_dout and bus_stb hold their values on the next clock. Each added wait cycle lengthens the beat by one clock.
- R5: An access with size code 2 or 3 (64-bit) is four beats, k = 0..3. The word field bus_adr[30:0] increases by k, so the byte address steps by 2. Beat k carries write data bits 16k+15:16k. The grant does not change until all four beats are acknowledged.
- R6: On a read, beat k's bus_din lands in read-data bits 16k+15:16k. A single-beat read yields {48'b0, bus_din}. The read data is valid while the one-cycle completion pulse is high, and that pulse comes only after the last beat's acknowledge.
- R7: When both masters request at the same time, the master other than the one that completed last is granted. The processor port wins the first such contest after reset.
- R8: A lone requester is granted whatever the priority state. A request that arrives during another master's transfer waits until that transfer completes.
- R9: bus_sel uses bit 1 for data bits 15:8 and bit 0 for bits 7:0. Size code 0 (byte) gives 2'b10 at an odd address and 2'b01 at an even one. Size codes 1, 2 and 3 give 2'b11.
- R10: bus_we follows the master's write flag. On writes bus_dout carries the beat's write data; on reads it is zero.
- R11: The two completion pulses are never high together, and each request gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | Processor write flag |
| cpu_siz | input | 2 | Processor size: 0 byte, 1 halfword, 2/3 64-bit |
| cpu_adr | input | 64 | Processor byte address |
| cpu_wdat | input | 64 | Processor write data |
| cpu_rdat | output | 64 | Processor gathered read data |
| cpu_done | output | 1 | Processor completion pulse |
| io_req | input | 1 | I/O-controller request, held until io_done |
| io_we | input | 1 | I/O-controller write flag |
| io_siz | input | 2 | I/O-controller size code |
| io_adr | input | 64 | I/O-controller byte address |
| io_wdat | input | 64 | I/O-controller write data |
| io_rdat | output | 64 | I/O-controller gathered read data |
| io_done | output | 1 | I/O-controller completion pulse |
| bus_cyc | output | 1 | Backplane cycle active |
| bus_stb | output | 1 | Backplane strobe |
| bus_we | output | 1 | Backplane write enable |
| bus_adr | output | 41 | Backplane address {A63:A54, A31:A1} |
| bus_sel | output | 2 | Backplane byte-lane selects |
| bus_dout | output | 16 | Backplane write data |
| bus_din | input | 16 | Backplane read data |
| bus_ack | input | 1 | Backplane acknowledge |

## Verification
The bridge registers a request in the clock after it is seen, so bus_stb rises one clock later. Each beat then lasts two clocks plus the slave's wait cycles, and the completion pulse and read data appear in the clock after the final acknowledge. The bench model slave raises bus_ack from a per-test wait count. It logs each beat's address, selects and data at the acknowledge, counts strobe clocks, and compares every held cycle of a beat with the beat's first cycle. Because of this, the bench compares whole-transfer results against the expected beat count and strobe length instead of at fixed absolute cycles. It drives and samples on the falling edge, counts completion pulses for two clocks after completion, and checks the order of completions for arbitration.

// File: rtl/bp_bridge.sv
module bp_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_siz,
  input  logic [63:0] cpu_adr,
  input  logic [63:0] cpu_wdat,
  output logic [63:0] cpu_rdat,
  output logic        cpu_done,
  input  logic        io_req,
  input  logic        io_we,
  input  logic [1:0]  io_siz,
  input  logic [63:0] io_adr,
  input  logic [63:0] io_wdat,
  output logic [63:0] io_rdat,
  output logic        io_done,
  output logic        bus_cyc,
  output logic        bus_stb,
  output logic        bus_we,
  output logic [40:0] bus_adr,
  output logic [1:0]  bus_sel,
  output logic [15:0] bus_dout,
  input  logic [15:0] bus_din,
  input  logic        bus_ack
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACK, S_DONE} st_t;

  st_t         st;
  logic        gnt, last;
  logic [63:0] adr_q, wd_q;
  logic        we_q;
  logic [1:0]  siz_q, beat;
  logic        pick;

  wire wide      = siz_q[1];
  wire last_beat = !wide || (beat == 2'd3);
  wire beat_ok   = (st == S_ACK) && bus_ack;

  always_comb begin
    if (cpu_req && io_req) pick = ~last;
    else                   pick = io_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      gnt   <= 1'b0;
      last  <= 1'b1;
      beat  <= 2'd0;
      adr_q <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
      siz_q <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req || io_req) begin
          gnt   <= pick;
          adr_q <= pick ? io_adr  : cpu_adr;
          wd_q  <= pick ? io_wdat : cpu_wdat;
          we_q  <= pick ? io_we   : cpu_we;
          siz_q <= pick ? io_siz  : cpu_siz;
          beat  <= 2'd0;
          st    <= S_ADDR;
        end
        S_ADDR: st <= S_ACK;
        S_ACK: if (bus_ack) begin
          if (last_beat) begin
            st   <= S_DONE;
            last <= gnt;
          end else begin
            beat <= beat + 2'd1;
            st   <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdat <= '0;
      io_rdat  <= '0;
    end else if (beat_ok && !we_q) begin
      if (gnt) begin
        if (beat == 2'd0) io_rdat <= {48'd0, bus_din};
        else              io_rdat[{beat, 4'd0} +: 16] <= bus_din;
      end else begin
        if (beat == 2'd0) cpu_rdat <= {48'd0, bus_din};
        else              cpu_rdat[{beat, 4'd0} +: 16] <= bus_din;
      end
    end
  end

  assign bus_cyc  = (st == S_ADDR) || (st == S_ACK);
  assign bus_stb  = bus_cyc;
  assign bus_we   = we_q;
  assign bus_adr  = {adr_q[63:54], adr_q[31:1] + {29'd0, beat}};
  assign bus_sel  = (siz_q == 2'd0) ? (adr_q[0] ? 2'b10 : 2'b01) : 2'b11;
  assign bus_dout = we_q ? wd_q[{beat, 4'd0} +: 16] : 16'd0;
  assign cpu_done = (st == S_DONE) && !gnt;
  assign io_done  = (st == S_DONE) && gnt;
endmodule

// File: rtl/bp_bridge_chk.sv
module bp_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic        bus_cyc,
  input logic        bus_stb,
  input logic        bus_we,
  input logic [40:0] bus_adr,
  input logic [1:0]  bus_sel,
  input logic [15:0] bus_dout,
  input logic        bus_ack,
  input logic        cpu_done,
  input logic        io_done
);
  localparam logic [1:0] ST_ADDR = 2'd1;
  localparam logic [1:0] ST_ACK  = 2'd2;

  assert_addr_then_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR) |=> (st == ST_ACK) && bus_stb && $stable(bus_adr));

  assert_stb_in_cyc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> bus_cyc);

  assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK && !bus_ack) |=> bus_stb && $stable(bus_adr) && $stable(bus_sel)
                                   && $stable(bus_we) && $stable(bus_dout));

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done || io_done) |-> $past(bus_ack) && !bus_stb);

  assert_single_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_done && io_done));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done || io_done) |=> !cpu_done && !io_done);
endmodule

bind bp_bridge bp_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .st(st),
  .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
  .bus_sel(bus_sel), .bus_dout(bus_dout), .bus_ack(bus_ack),
  .cpu_done(cpu_done), .io_done(io_done)
);

// File: tb/bp_bridge_tb.sv
module bp_bridge_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0]  m_req = 0, m_we = 0;
  logic [1:0]  m_siz [2];
  logic [63:0] m_adr [2];
  logic [63:0] m_wd  [2];
  logic [63:0] rd0, rd1;
  logic dn0, dn1;
  logic bus_cyc, bus_stb, bus_we, bus_ack;
  logic [40:0] bus_adr;
  logic [1:0]  bus_sel;
  logic [15:0] bus_dout, bus_din;

  int nchk = 0, nerr = 0;
  int waits = 0, cnt = 0, stb_cyc = 0, hold_err = 0, lg_n = 0;
  logic [40:0] lg_adr [16];
  logic [1:0]  lg_sel [16];
  logic [15:0] lg_dat [16];
  logic        lg_we  [16];
  logic [40:0] ref_adr;
  logic [1:0]  ref_sel;
  logic [15:0] ref_dat;

  always #(CLK_P/2) clk = ~clk;

  bp_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(m_req[0]), .cpu_we(m_we[0]), .cpu_siz(m_siz[0]), .cpu_adr(m_adr[0]),
    .cpu_wdat(m_wd[0]), .cpu_rdat(rd0), .cpu_done(dn0),
    .io_req(m_req[1]), .io_we(m_we[1]), .io_siz(m_siz[1]), .io_adr(m_adr[1]),
    .io_wdat(m_wd[1]), .io_rdat(rd1), .io_done(dn1),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_sel(bus_sel), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  function automatic logic [15:0] rdf(logic [40:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  function automatic logic [40:0] xadr(logic [63:0] a, int k);
    return {a[63:54], a[31:1] + 31'(k)};
  endfunction

  assign bus_din = rdf(bus_adr);

  initial bus_ack = 0;
  always @(negedge clk) begin
    if (!bus_stb) begin
      cnt = 0; bus_ack = 0;
    end else begin
      if (bus_ack) begin
        bus_ack = 0; cnt = 0;
      end
      cnt++;
      stb_cyc++;
      if (cnt == 1) begin
        ref_adr = bus_adr; ref_sel = bus_sel; ref_dat = bus_dout;
      end else if (bus_adr !== ref_adr || bus_sel !== ref_sel || bus_dout !== ref_dat) begin
        hold_err++;
      end
      if (cnt >= 2 + waits) begin
        bus_ack = 1;
        if (lg_n < 16) begin
          lg_adr[lg_n] = bus_adr; lg_sel[lg_n] = bus_sel;
          lg_dat[lg_n] = bus_dout; lg_we[lg_n] = bus_we;
        end
        lg_n++;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    lg_n = 0; stb_cyc = 0; hold_err = 0;
  endtask

  task automatic do_req(int w, logic we, logic [1:0] siz, logic [63:0] a, logic [63:0] wd,
                        output logic [63:0] rd, output int pulses);
    @(negedge clk);
    clr_log();
    m_we[w] = we; m_siz[w] = siz; m_adr[w] = a; m_wd[w] = wd; m_req[w] = 1;
    do @(negedge clk); while (!(w == 0 ? dn0 : dn1));
    rd = (w == 0) ? rd0 : rd1;
    pulses = 1;
    m_req[w] = 0;
    repeat (2) begin
      @(negedge clk);
      if (w == 0 ? dn0 : dn1) pulses++;
    end
  endtask

  task automatic do_reset();
    rst_n = 0; m_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 idle bus", {bus_cyc, bus_stb, dn0, dn1}, 4'b0000);
  endtask

  task automatic t_byte_write();
    logic [63:0] rd; int p;
    logic [63:0] a = 64'hA5C0_0000_1234_5679;
    waits = 0;
    do_req(0, 1, 2'd0, a, 64'h1111_2222_3333_AB00, rd, p);
    chk("R2 beats", lg_n, 1);
    chk("R2 stb clocks", stb_cyc, 2);
    chk("R3 address", lg_adr[0], xadr(a, 0));
    chk("R9 odd byte sel", lg_sel[0], 2'b10);
    chk("R10 write data", {lg_we[0], lg_dat[0]}, {1'b1, 16'hAB00});
    chk("R11 one pulse", p, 1);
  endtask

  task automatic t_even_byte_and_mask();
    logic [63:0] rd; int p;
    logic [40:0] first;
    logic [63:0] a = 64'h0040_0000_0000_8002;
    waits = 0;
    do_req(1, 1, 2'd0, a, 64'h0000_0000_0000_00CD, rd, p);
    first = lg_adr[0];
    chk("R9 even byte sel", lg_sel[0], 2'b01);
    do_req(1, 1, 2'd0, a | 64'h003F_FFFF_0000_0000, 64'hCD, rd, p);
    chk("R3 bits 53:32 ignored", lg_adr[0], first);
    chk("R8 lone io granted", p, 1);
  endtask

  task automatic t_half_read();
    logic [63:0] rd; int p;
    logic [63:0] a = 64'hFFC0_0000_8765_4320;
    waits = 0;
    do_req(1, 0, 2'd1, a, 64'hFFFF, rd, p);
    chk("R6 single read", rd, {48'd0, rdf(xadr(a, 0))});
    chk("R10 read dout zero", {lg_we[0], lg_dat[0]}, 17'd0);
    chk("R9 half sel", lg_sel[0], 2'b11);
  endtask

  task automatic t_wait();
    logic [63:0] rd; int p;
    waits = 3;
    do_req(0, 1, 2'd1, 64'h0000_0000_0000_0100, 64'hBEEF, rd, p);
    chk("R4 stb clocks with waits", stb_cyc, 5);
    chk("R4 held during waits", hold_err, 0);
    chk("R4 data", lg_dat[0], 16'hBEEF);
    waits = 0;
  endtask

  task automatic t_wide_read();
    logic [63:0] rd; int p;
    logic [63:0] a = 64'hC0FF_EE00_1234_5670;
    logic [63:0] exp;
    waits = 1;
    do_req(0, 0, 2'd2, a, 0, rd, p);
    chk("R5 four beats", lg_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 ascending address", lg_adr[k], xadr(a, k));
      exp[16*k +: 16] = rdf(xadr(a, k));
    end
    chk("R5 stb clocks", stb_cyc, 12);
    chk("R6 gathered read", rd, exp);
    chk("R6 one pulse", p, 1);
    waits = 0;
  endtask

  task automatic t_wide_write();
    logic [63:0] rd; int p;
    logic [63:0] wd = 64'h4444_3333_2222_1111;
    waits = 2;
    do_req(1, 1, 2'd3, 64'h0000_0000_0000_2000, wd, rd, p);
    chk("R5 four beats", lg_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 beat data", lg_dat[k], wd[16*k +: 16]);
      chk("R9 wide sel", lg_sel[k], 2'b11);
    end
    chk("R4 held", hold_err, 0);
    waits = 0;
  endtask

  task automatic both(output int first);
    @(negedge clk);
    clr_log();
    for (int w = 0; w < 2; w++) begin
      m_we[w] = 1; m_siz[w] = 2'd1; m_adr[w] = 64'h100 * (w + 1); m_wd[w] = 64'(w);
    end
    m_req = 2'b11;
    first = -1;
    while (m_req != 0) begin
      @(negedge clk);
      if (dn0 && dn1) begin nchk++; nerr++; $display("FAIL R11 both pulses actual=11 expected=one"); end
      if (dn0) begin m_req[0] = 0; if (first < 0) first = 0; end
      if (dn1) begin m_req[1] = 0; if (first < 0) first = 1; end
    end
  endtask

  task automatic t_rr();
    int f; logic [63:0] rd; int p;
    do_reset();
    waits = 0;
    both(f);
    chk("R7 cpu wins after reset", f, 0);
    do_req(0, 1, 2'd1, 64'h40, 64'h7, rd, p);
    both(f);
    chk("R7 io wins after cpu", f, 1);
    both(f);
    chk("R7 alternates", f, 1);
  endtask

  task automatic t_lock();
    logic [63:0] a = 64'h0000_0000_0000_4000;
    waits = 0;
    @(negedge clk);
    clr_log();
    m_we = 2'b11; m_siz[0] = 2'd2; m_adr[0] = a; m_wd[0] = 64'h1;
    m_siz[1] = 2'd1; m_adr[1] = 64'h0000_0000_0000_9000; m_wd[1] = 64'h2;
    m_req[0] = 1;
    repeat (3) @(negedge clk);
    m_req[1] = 1;
    while (m_req != 0) begin
      @(negedge clk);
      if (dn0) m_req[0] = 0;
      if (dn1) m_req[1] = 0;
    end
    chk("R8 total beats", lg_n, 5);
    for (int k = 0; k < 4; k++) chk("R8 locked cpu beats", lg_adr[k], xadr(a, k));
    chk("R8 io after cpu", lg_adr[4], xadr(64'h9000, 0));
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin m_siz[w] = 0; m_adr[w] = 0; m_wd[w] = 0; end
    t_reset();
    t_byte_write();
    t_even_byte_and_mask();
    t_half_read();
    t_wait();
    t_wide_read();
    t_wide_write();
    t_rr();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule